// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that finishes one instruction in every clock cycle. It decodes a small integer subset: wrapping add and subtract between registers, OR with a zero-extended 16-bit constant, word load, word store and a conditional branch on register equality. The program counter, a 32 x 32-bit register file and the data memory all change state on the same rising clock edge. Between edges the fetch, decode, operand read, ALU, memory read and write-back form one combinational path.

Program words reach an internal instruction array through a preload port, normally while reset is held. Data memory is a word array inside the core. It reads combinationally and writes on the clock edge. Debug outputs carry the current program counter and the register-file write port, which lets a bench follow execution one instruction at a time.

The decoder sorts each word into one of seven instruction classes: ADDU, SUBU, ORI, LW, SW, BEQ and NOP. The control word for the datapath is then produced from the class. The next-PC path has two transitions. SEQ goes to PC+4. TAKEN goes to PC+4 plus the scaled offset, and is followed only by a BEQ whose operands match.

Top module: `mini_cpu_core`

## Requirements
- R1: A synchronous active-high reset loads PC 0. While reset is high, no register or data-memory write takes place, and `dbg_wr_en` stays 0.
- R2: Instruction fields use fixed positions. The opcode is [31:26], the first source register is [25:21], the second source or I-format destination is [20:16], the R-format destination is [15:11], the shift field is [10:6], the function code is [5:0] and the 16-bit immediate is [15:0].
- R3: With opcode 0x00 and shift field 0, function code 0x21 writes rs+rt into rd and function code 0x23 writes rs-rt into rd. Both wrap modulo 2^32 and report no overflow.
- R4: Opcode 0x0D writes rs OR the zero-extended immediate into rt.
- R5: Opcode 0x23 writes into rt the data word at rs + sign-extended immediate. Address bits [1:0] are ignored when the word is selected.
- R6: Opcode 0x2B writes rt into the data word at rs + sign-extended immediate and writes no register.
- R7: Opcode 0x04 moves the PC to PC+4+(sign-extended immediate x 4) when rs equals rt, and to PC+4 otherwise. It writes no register.
- R8: Register 0 always reads as zero. An instruction that targets register 0 writes nothing and leaves `dbg_wr_en` at 0.
- R9: Any other opcode, any other function code, and an R-format word with a nonzero shift field each act as a no-op: no writes, and the PC advances by 4.
- R10: A register or data word written at one edge is seen by the instruction that runs in the next cycle.
- R11: `dbg_pc` shows the PC of the instruction currently executing. `dbg_wr_en`, `dbg_wr_idx` and `dbg_wr_data` show the register write that this instruction will make at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state element updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Preload write strobe for the instruction array |
| imem_waddr | input | 6 | Word index for the preload write |
| imem_wdata | input | 32 | Instruction word to preload |
| dbg_pc | output | 32 | Program counter of the executing instruction |
| dbg_wr_en | output | 1 | A register write will occur at the next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
Because every state element shares one edge, one instruction's write and the next instruction's read can fall in adjacent cycles with nothing in between. The bench exercises this in two ways. An add reads two registers that were written in the two cycles just before it, and a store is followed at once by a load of the same word through a different, misaligned address. Both are judged by comparing the write-port value against the expected result in the cycle the load or add executes. The branch taken/not-taken decision, which depends on those freshly written registers, is judged through the PC sequence.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU   = 6'h21;
    localparam logic [5:0] FN_SUBU   = 6'h23;

    typedef enum logic [2:0] {
        INS_ADDU, INS_SUBU, INS_ORI, INS_LW, INS_SW, INS_BEQ, INS_NOP
    } ins_kind_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_OR
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    src_imm;
        logic    ext_sign;
        logic    mem_we;
        logic    wb_mem;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
    parameter int W       = 32,
    parameter int ENTRIES = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] regs [ENTRIES];

    // Entry 0 is never written; the read ports force it to zero.
    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    always_comb begin
        rd_a = (ra_a == '0) ? '0 : regs[ra_a];
        rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    end

endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
    import mcc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] shamt,
    input  logic [5:0] funct,
    output ins_kind_e  kind,
    output ctrl_t      ctrl
);

    // Classification step.
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: begin
                if (shamt != '0)            kind = INS_NOP;
                else if (funct == FN_ADDU)  kind = INS_ADDU;
                else if (funct == FN_SUBU)  kind = INS_SUBU;
                else                        kind = INS_NOP;
            end
            OPC_ORI: kind = INS_ORI;
            OPC_LW:  kind = INS_LW;
            OPC_SW:  kind = INS_SW;
            OPC_BEQ: kind = INS_BEQ;
            default: kind = INS_NOP;
        endcase
    end

    // Control word produced from the class.
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, src_imm: 1'b0, ext_sign: 1'b1,
                 mem_we: 1'b0, wb_mem: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD};
        unique case (kind)
            INS_ADDU: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
            end
            INS_SUBU: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            INS_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.ext_sign = 1'b0;
                ctrl.alu_op   = ALU_OR;
            end
            INS_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
            end
            INS_SW: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            INS_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: begin
                ctrl.reg_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mcc_alu.sv
module mcc_alu
    import mcc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/mini_cpu_core.sv
module mini_cpu_core
    import mcc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW       = $clog2(IMEM_WORDS),
    localparam int DAW       = $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imem_we,
    input  logic [IAW-1:0]    imem_waddr,
    input  logic [XLEN-1:0]   imem_wdata,
    output logic [XLEN-1:0]   dbg_pc,
    output logic              dbg_wr_en,
    output logic [REG_AW-1:0] dbg_wr_idx,
    output logic [XLEN-1:0]   dbg_wr_data
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_off;
    logic [XLEN-1:0]   instr;
    logic [5:0]        f_op, f_fn;
    logic [4:0]        f_sh;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd, dst_idx;
    logic [15:0]       f_imm;
    logic [XLEN-1:0]   imm_ext, rs_val, rt_val, alu_b, alu_y, ld_val, wb_val;
    logic              alu_zero, br_take, reg_we_eff, mem_we_eff;
    logic [DAW-1:0]    d_idx;
    ins_kind_e         kind;
    ctrl_t             ctrl;

    // Instruction array preload port.
    always_ff @(posedge clk) begin
        if (imem_we) begin
            imem[imem_waddr] <= imem_wdata;
        end
    end

    // Fetch and field split.
    always_comb begin
        instr = imem[pc_q[IAW+1:2]];
        f_op  = instr[31:26];
        f_rs  = instr[25:21];
        f_rt  = instr[20:16];
        f_rd  = instr[15:11];
        f_sh  = instr[10:6];
        f_fn  = instr[5:0];
        f_imm = instr[15:0];
    end

    mcc_decode u_decode (
        .opcode (f_op),
        .shamt  (f_sh),
        .funct  (f_fn),
        .kind   (kind),
        .ctrl   (ctrl)
    );

    mcc_regfile #(.W(XLEN), .ENTRIES(1 << REG_AW)) u_regs (
        .clk   (clk),
        .we    (reg_we_eff),
        .waddr (dst_idx),
        .wdata (wb_val),
        .ra_a  (f_rs),
        .ra_b  (f_rt),
        .rd_a  (rs_val),
        .rd_b  (rt_val)
    );

    always_comb begin
        imm_ext = ctrl.ext_sign ? {{(XLEN-16){f_imm[15]}}, f_imm}
                                : {{(XLEN-16){1'b0}}, f_imm};
        alu_b   = ctrl.src_imm ? imm_ext : rt_val;
    end

    mcc_alu #(.W(XLEN)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory: combinational read, edge write.
    always_comb begin
        d_idx      = alu_y[DAW+1:2];
        ld_val     = dmem[d_idx];
        mem_we_eff = ctrl.mem_we && !rst;
    end

    always_ff @(posedge clk) begin
        if (mem_we_eff) begin
            dmem[d_idx] <= rt_val;
        end
    end

    // Write-back steering.
    always_comb begin
        wb_val     = ctrl.wb_mem ? ld_val : alu_y;
        dst_idx    = ctrl.dst_is_rd ? f_rd : f_rt;
        reg_we_eff = ctrl.reg_we && !rst && (dst_idx != '0);
    end

    // Next-PC selection: SEQ or TAKEN.
    always_comb begin
        pc_plus4 = pc_q + XLEN'(4);
        br_off   = {imm_ext[XLEN-3:0], 2'b00};
        br_take  = ctrl.is_branch && alu_zero;
        pc_next  = br_take ? (pc_plus4 + br_off) : pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    always_comb begin
        dbg_pc      = pc_q;
        dbg_wr_en   = reg_we_eff;
        dbg_wr_idx  = dst_idx;
        dbg_wr_data = wb_val;
    end

    AST_RESET_NO_WRITE: assert property (@(posedge clk)
        rst |-> (!dbg_wr_en && !mem_we_eff)); // R1
    AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
        !br_take |=> (pc_q == $past(pc_q) + XLEN'(4))); // R9
    AST_PC_TAKEN: assert property (@(posedge clk) disable iff (rst)
        br_take |=> (pc_q == $past(pc_q) + XLEN'(4) + {$past(f_imm[15]) ? 14'h3FFF : 14'h0, $past(f_imm), 2'b00})); // R7
    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (f_rs == '0) |-> (rs_val == '0)); // R8
    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
        mem_we_eff |=> (dmem[$past(d_idx)] == $past(rt_val))); // R6
    AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (rst)
        (kind == INS_SW || kind == INS_BEQ) |-> !dbg_wr_en); // R6

endmodule

// File: tb/mini_cpu_core_tb.sv
module mini_cpu_core_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] T_RT = 6'h00, T_ORI = 6'h0D, T_LW = 6'h23,
                           T_SW = 6'h2B, T_BEQ = 6'h04, T_ADDU = 6'h21, T_SUBU = 6'h23;

    typedef struct packed {
        logic [31:0] pc;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        imem_we;
    logic [5:0]  imem_waddr;
    logic [31:0] imem_wdata;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_data;

    int    n_chk  = 0;
    int    n_fail = 0;
    logic  mon_on = 1'b0;
    logic  done   = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [31:0] prog [18];

    mini_cpu_core u_dut (
        .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
        .imem_wdata(imem_wdata), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
        .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
        return {T_RT, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] pc, input logic we, input logic [4:0] idx,
                        input logic [31:0] data, input string tag);
        exp_q.push_back('{pc: pc, we: we, idx: idx, data: data});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the scoreboard head against the ports every cycle.
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (mon_on && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "pc", dbg_pc, e.pc);
            check(t, "wr_en", {31'd0, dbg_wr_en}, {31'd0, e.we});
            if (e.we) begin
                check(t, "wr_idx", {27'd0, dbg_wr_idx}, {27'd0, e.idx});
                check(t, "wr_data", dbg_wr_data, e.data);
            end
        end
    end

    // Driver.
    initial begin
        rst = 1'b1; imem_we = 1'b0; imem_waddr = '0; imem_wdata = '0;

        prog[0]  = enc_i(T_ORI, 5'd0, 5'd1, 16'h8001);
        prog[1]  = enc_i(T_ORI, 5'd0, 5'd2, 16'h0003);
        prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 5'd0, T_ADDU);
        prog[3]  = enc_r(5'd2, 5'd1, 5'd4, 5'd0, T_SUBU);
        prog[4]  = enc_i(T_SW, 5'd0, 5'd3, 16'd8);
        prog[5]  = enc_i(T_LW, 5'd2, 5'd5, 16'd8);
        prog[6]  = enc_i(T_ORI, 5'd0, 5'd6, 16'd16);
        prog[7]  = enc_i(T_LW, 5'd6, 5'd7, 16'hFFF8);
        prog[8]  = enc_r(5'd1, 5'd2, 5'd0, 5'd0, T_ADDU);
        prog[9]  = enc_r(5'd0, 5'd2, 5'd8, 5'd0, T_ADDU);
        prog[10] = {6'h3F, 5'd1, 5'd10, 16'h1234};
        prog[11] = enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'h20);
        prog[12] = enc_r(5'd1, 5'd2, 5'd10, 5'd5, T_ADDU);
        prog[13] = enc_i(T_BEQ, 5'd3, 5'd5, 16'd2);
        prog[14] = enc_i(T_ORI, 5'd0, 5'd9, 16'hDEAD);
        prog[15] = enc_i(T_ORI, 5'd0, 5'd9, 16'hBEEF);
        prog[16] = enc_i(T_BEQ, 5'd1, 5'd2, 16'd5);
        prog[17] = enc_i(T_BEQ, 5'd0, 5'd0, 16'hFFFF);

        repeat (2) @(posedge clk);
        #1 check("R1", "pc in reset", dbg_pc, 32'd0);
        check("R1", "wr_en in reset", {31'd0, dbg_wr_en}, 32'd0);

        for (int i = 0; i < 18; i++) begin
            @(posedge clk);
            #1 imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
        end
        @(posedge clk);
        #1 imem_we = 1'b0;

        push(32'd0,  1, 5'd1, 32'h0000_8001, "R4 zero-extend");
        push(32'd4,  1, 5'd2, 32'd3,         "R4");
        push(32'd8,  1, 5'd3, 32'h0000_8004, "R3 add / R10 fresh regs");
        push(32'd12, 1, 5'd4, 32'hFFFF_8002, "R3 sub wrap");
        push(32'd16, 0, 5'd0, 32'd0,         "R6 store");
        push(32'd20, 1, 5'd5, 32'h0000_8004, "R5 misaligned / R10 store-load");
        push(32'd24, 1, 5'd6, 32'd16,        "R11");
        push(32'd28, 1, 5'd7, 32'h0000_8004, "R5 negative offset");
        push(32'd32, 0, 5'd0, 32'd0,         "R8 write r0");
        push(32'd36, 1, 5'd8, 32'd3,         "R8 read r0");
        push(32'd40, 0, 5'd0, 32'd0,         "R9 bad opcode");
        push(32'd44, 0, 5'd0, 32'd0,         "R9 bad funct");
        push(32'd48, 0, 5'd0, 32'd0,         "R9 shift field / R2");
        push(32'd52, 0, 5'd0, 32'd0,         "R7 taken");
        push(32'd64, 0, 5'd0, 32'd0,         "R7 target");
        push(32'd68, 0, 5'd0, 32'd0,         "R7 not taken");
        push(32'd68, 0, 5'd0, 32'd0,         "R7 backward");
        push(32'd68, 0, 5'd0, 32'd0,         "R7 loop");

        @(posedge clk);
        #1 rst = 1'b0; mon_on = 1'b1;
        wait (exp_q.size() == 0);
        @(posedge clk);
        #1 rst = 1'b1; mon_on = 1'b0;
        @(negedge clk);
        check("R1", "wr_en with reset raised", {31'd0, dbg_wr_en}, 32'd0);
        @(posedge clk);
        #1 check("R1", "pc after reset", dbg_pc, 32'd0);
        check("R1", "wr_en suppressed at pc 0", {31'd0, dbg_wr_en}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule